// File: doc/BRIEF.md
# E3 Transmit Overhead Insertion Port

This block sits in the transmit path of an E3 framer and lets external system logic overwrite the twelve overhead bits at the start of each outbound frame, one bit at a time. The serial stream enters on `tx_in`, one bit per line clock. It leaves on `tx_out` one clock later. An internal frame counter gives each input bit a position from 0 to `FRAME_LEN-1`, and the counter starts at position 0 when reset is released. Positions 0 to 11 are the overhead: a ten-bit alignment word, then the remote alarm bit at index 10, then the national bit at index 11. Every other position is payload and passes through unchanged.

During the last `2*12` line clocks of each frame the block runs the overhead handshake. It raises `oh_clk` for one line clock per overhead bit, with one low clock between pulses. It raises `oh_frame` during the pulse for index 0 and the low clock after it. External logic counts pulses from the marker. Pulse k carries index k, so the remote alarm bit is pulse 10. External logic drives `oh_ins` and `oh_dat` while `oh_clk` is high. The block latches them on the line-clock edge where `oh_clk` falls. A latched value with `oh_ins` high replaces the internal default for that index. With `oh_ins` low the default is kept. The twelve collected values are moved to the transmit register as the frame wraps, so they appear in the overhead of the frame that follows. To signal far-end receive failure, external logic drives the A bit to 1.

A three-state machine steps through the handshake:
- `ST_PAYLOAD` moves to `ST_OH_HIGH` with index 0 on the clock before position `FRAME_LEN-24` (the transition is named *window open*).
- `ST_OH_HIGH` always moves to `ST_OH_LOW`. This transition is named *capture*, and the inputs are latched on it.
- `ST_OH_LOW` moves back to `ST_OH_HIGH` with the index increased by one (*next bit*).
- After index 11, `ST_OH_LOW` moves to `ST_PAYLOAD` instead (*window close*). That clock is the last position of the frame, and the collected values are copied to the transmit register on it.

`FRAME_LEN` must be at least 36.

Top module: `e3oh_insert_port`

## Requirements
- R1: While reset is asserted, `tx_out`, `oh_clk` and `oh_frame` are 0. The first `tx_in` bit sampled after release is frame position 0.
- R2: Within each frame, `oh_clk` is high for exactly one line clock at each position `FRAME_LEN-24+2k`, for k = 0 to 11. It is low at every other position.
- R3: `oh_frame` is high at positions `FRAME_LEN-24` and `FRAME_LEN-23` only. These are the pulse for index 0 and the low clock after it.
- R4: `oh_ins` and `oh_dat` are sampled only on the clock edge that ends an `oh_clk` high cycle. Their values at any other time have no effect on `tx_out`.
- R5: If `oh_ins` is 1 when pulse k is sampled, the sampled `oh_dat` is transmitted at position k of the next frame. It appears on `tx_out` one clock after `tx_in` is sampled at that position.
- R6: If `oh_ins` is 0 when pulse k is sampled, position k of the next frame carries the default. Indices 0 to 9 carry 1,1,1,1,0,1,0,0,0,0, index 10 (A) carries 0 and index 11 (N) carries 1.
- R7: Inserting 1 at pulse index 10 sets the remote alarm bit (position 10) of the next frame to 1, which signals far-end receive failure.
- R8: At positions 12 to `FRAME_LEN-1`, `tx_out` equals the `tx_in` value sampled one clock earlier.
- R9: The first frame after reset carries the default overhead of R6.
- R10: An override does not persist. An index that is not inserted in a window returns to its default in the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in | input | 1 | Serial frame stream, one bit per clock |
| tx_out | output | 1 | Serial stream with overhead applied, one clock behind `tx_in` |
| oh_clk | output | 1 | Overhead handshake pulse, one per overhead bit |
| oh_frame | output | 1 | Marker for overhead index 0 |
| oh_ins | input | 1 | Insert enable, sampled when `oh_clk` falls |
| oh_dat | input | 1 | Overhead value, sampled when `oh_clk` falls |

## Verification
The bench builds the block with `FRAME_LEN` = 64 instead of the default 1536. With a short frame, eight consecutive frames fit in a few hundred clocks, so one run can chain frames whose handshake plans differ: noise-only, A-bit only, full insertion, alternate-index insertion with inverted values, quiet, and random. Each frame then checks the effect of the previous window. Because the handshake window starts at position 40, it leaves 28 payload positions per frame for pass-through checks. A reset in the middle of a frame, followed by three more frames, checks the restart at position 0 and the return of the default overhead.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;

    // Overhead bits per E3 frame: ten alignment bits, alarm bit, national bit
    localparam int OH_BITS = 12;

    // Default overhead, bit i of the vector = overhead index i
    // indices 0..9: 1111010000, index 10 (A) = 0, index 11 (N) = 1
    localparam logic [OH_BITS-1:0] OH_DEFAULT = 12'h82F;

    typedef enum logic [1:0] {
        ST_PAYLOAD = 2'd0,
        ST_OH_HIGH = 2'd1,
        ST_OH_LOW  = 2'd2
    } oh_state_e;

endpackage

// File: rtl/e3oh_pos_counter.sv
module e3oh_pos_counter #(
    parameter int FRAME_LEN = 1536,
    parameter int PW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] pos
);

    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (pos == LAST_POS) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // Frame timing wraps after the last position (R2 window placement)
    assert_pos_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == LAST_POS) |=> (pos == '0));

endmodule

// File: rtl/e3oh_strobe_fsm.sv
module e3oh_strobe_fsm
    import e3oh_pkg::*;
#(
    parameter int FRAME_LEN = 1536,
    parameter int PW        = $clog2(FRAME_LEN),
    parameter int IW        = $clog2(OH_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pos,
    output logic          oh_clk,
    output logic          oh_frame,
    output logic          cap_en,
    output logic [IW-1:0] cap_idx,
    output logic          frame_end
);

    localparam int            WIN_START = FRAME_LEN - 2 * OH_BITS;
    localparam logic [PW-1:0] WIN_PRE   = PW'(WIN_START - 1);
    localparam logic [PW-1:0] WIN_POS   = PW'(WIN_START);
    localparam logic [IW-1:0] IDX_LAST  = IW'(OH_BITS - 1);

    oh_state_e     state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PAYLOAD;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions: window open, capture, next bit, window close
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_PAYLOAD: begin
                if (pos == WIN_PRE) begin
                    state_d = ST_OH_HIGH;
                    idx_d   = '0;
                end
            end
            ST_OH_HIGH: begin
                state_d = ST_OH_LOW;
            end
            ST_OH_LOW: begin
                if (idx_q == IDX_LAST) begin
                    state_d = ST_PAYLOAD;
                end else begin
                    state_d = ST_OH_HIGH;
                    idx_d   = idx_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_PAYLOAD;
                idx_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        oh_clk    = (state_q == ST_OH_HIGH);
        cap_en    = (state_q == ST_OH_HIGH);
        cap_idx   = idx_q;
        oh_frame  = (state_q != ST_PAYLOAD) && (idx_q == '0);
        frame_end = (state_q == ST_OH_LOW) && (idx_q == IDX_LAST);
    end

    // pulses sit only on even offsets inside the handshake window (R2)
    assert_pulse_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oh_clk |-> ((pos >= WIN_POS) && (((pos - WIN_POS) & PW'(1)) == '0)));

    // each pulse lasts one clock (R2)
    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oh_clk |=> !oh_clk);

    // marker starts together with a pulse (R3)
    assert_marker_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oh_frame) |-> oh_clk);

    // marker only at the first two window positions (R3)
    assert_marker_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        oh_frame |-> ((pos == WIN_POS) || (pos == WIN_POS + 1'b1)));

endmodule

// File: rtl/e3oh_ovr_path.sv
module e3oh_ovr_path
    import e3oh_pkg::*;
#(
    parameter int PW = 11,
    parameter int IW = $clog2(OH_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pos,
    input  logic          tx_in,
    input  logic          cap_en,
    input  logic [IW-1:0] cap_idx,
    input  logic          frame_end,
    input  logic          oh_ins,
    input  logic          oh_dat,
    output logic          tx_out
);

    localparam logic [PW-1:0] OH_END = PW'(OH_BITS);

    logic [OH_BITS-1:0] shadow_q;
    logic [OH_BITS-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= OH_DEFAULT;
            active_q <= OH_DEFAULT;
            tx_out   <= 1'b0;
        end else begin
            if (cap_en) begin
                shadow_q[cap_idx] <= oh_ins ? oh_dat : OH_DEFAULT[cap_idx];
            end
            if (frame_end) begin
                active_q <= shadow_q;
            end
            if (pos < OH_END) begin
                tx_out <= active_q[pos[IW-1:0]];
            end else begin
                tx_out <= tx_in;
            end
        end
    end

    // payload positions pass through with one clock of latency (R8)
    assert_payload_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= OH_END) |=> (tx_out == $past(tx_in)));

    // an inserted value lands in the collection register (R5)
    assert_insert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && oh_ins) |=> (shadow_q[$past(cap_idx)] == $past(oh_dat)));

    // a skipped index falls back to its default (R6)
    assert_default_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !oh_ins) |=> (shadow_q[$past(cap_idx)] == OH_DEFAULT[$past(cap_idx)]));

endmodule

// File: rtl/e3oh_insert_port.sv
module e3oh_insert_port
    import e3oh_pkg::*;
#(
    parameter int FRAME_LEN = 1536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in,
    output logic tx_out,
    output logic oh_clk,
    output logic oh_frame,
    input  logic oh_ins,
    input  logic oh_dat
);

    localparam int PW = $clog2(FRAME_LEN);
    localparam int IW = $clog2(OH_BITS);

    logic [PW-1:0] pos;
    logic          cap_en;
    logic [IW-1:0] cap_idx;
    logic          frame_end;

    e3oh_pos_counter #(
        .FRAME_LEN (FRAME_LEN),
        .PW        (PW)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (pos)
    );

    e3oh_strobe_fsm #(
        .FRAME_LEN (FRAME_LEN),
        .PW        (PW),
        .IW        (IW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos       (pos),
        .oh_clk    (oh_clk),
        .oh_frame  (oh_frame),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .frame_end (frame_end)
    );

    e3oh_ovr_path #(
        .PW (PW),
        .IW (IW)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos       (pos),
        .tx_in     (tx_in),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .frame_end (frame_end),
        .oh_ins    (oh_ins),
        .oh_dat    (oh_dat),
        .tx_out    (tx_out)
    );

    // the collection register is copied at the last frame position,
    // right before position 0 is transmitted (R5)
    assert_copy_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (pos == '0));

endmodule

// File: tb/e3oh_insert_port_tb.sv
module e3oh_insert_port_tb;

    localparam int FRAME_LEN = 64;
    localparam int OHB       = 12;
    localparam int WIN       = FRAME_LEN - 2 * OHB;
    localparam logic [OHB-1:0] DEF = 12'h82F; // index i = bit i

    typedef struct {
        logic  exp;
        string tag;
        int    pos;
    } item_t;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_in;
    logic tx_out;
    logic oh_clk;
    logic oh_frame;
    logic oh_ins;
    logic oh_dat;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    item_t sbq[$];

    int    bpos;
    int    frame;
    logic  cur_oh   [OHB];
    logic  nxt_oh   [OHB];
    string cur_tag  [OHB];
    logic  plan_ins [OHB];
    logic  plan_dat [OHB];
    string plan_tag [OHB];

    always #5 clk = ~clk;

    e3oh_insert_port #(.FRAME_LEN(FRAME_LEN)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_in    (tx_in),
        .tx_out   (tx_out),
        .oh_clk   (oh_clk),
        .oh_frame (oh_frame),
        .oh_ins   (oh_ins),
        .oh_dat   (oh_dat)
    );

    task automatic check_bit(string tag, string what, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected output bits away from the clock edge
    always @(posedge clk) begin
        #2;
        if (rst_n && sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check_bit(it.tag, $sformatf("tx_out pos %0d frame %0d", it.pos, frame), tx_out, it.exp);
        end
    end

    // handshake plan for the window of frame f
    task automatic make_plan(int f);
        for (int k = 0; k < OHB; k++) begin
            unique case (f % 6)
                0: begin plan_ins[k] = 1'b0; plan_dat[k] = 1'b1; plan_tag[k] = "R4"; end
                1: begin
                    plan_ins[k] = (k == 10);
                    plan_dat[k] = 1'b1;
                    plan_tag[k] = (k == 10) ? "R7" : "R6";
                end
                2: begin plan_ins[k] = 1'b1; plan_dat[k] = 1'($urandom); plan_tag[k] = "R5"; end
                3: begin
                    plan_ins[k] = (k % 2 == 0);
                    plan_dat[k] = ~DEF[k];
                    plan_tag[k] = (k % 2 == 0) ? "R5" : "R6";
                end
                4: begin plan_ins[k] = 1'b0; plan_dat[k] = 1'b1; plan_tag[k] = "R10"; end
                default: begin
                    plan_ins[k] = 1'($urandom);
                    plan_dat[k] = 1'($urandom);
                    plan_tag[k] = plan_ins[k] ? "R5" : "R6";
                end
            endcase
        end
    endtask

    task automatic restart_model();
        bpos  = 0;
        frame = 0;
        for (int k = 0; k < OHB; k++) begin
            cur_oh[k]  = DEF[k];
            nxt_oh[k]  = DEF[k];
            cur_tag[k] = "R9";
        end
        make_plan(0);
    endtask

    // driver: one line clock, called at a falling clock edge
    task automatic step();
        item_t it;
        bit pulse;
        pulse = (bpos >= WIN) && (((bpos - WIN) % 2) == 0);
        check_bit("R2", $sformatf("oh_clk pos %0d", bpos), oh_clk, pulse);
        check_bit("R3", $sformatf("oh_frame pos %0d", bpos), oh_frame,
                  (bpos == WIN) || (bpos == WIN + 1));
        if (pulse) begin
            int k;
            k = (bpos - WIN) / 2;
            oh_ins = plan_ins[k];
            oh_dat = plan_dat[k];
            nxt_oh[k] = plan_ins[k] ? plan_dat[k] : DEF[k];
        end else begin
            // off-edge noise, must be ignored (R4)
            oh_ins = 1'($urandom);
            oh_dat = 1'($urandom);
        end
        tx_in = 1'($urandom);
        it.pos = bpos;
        if (bpos < OHB) begin
            it.exp = cur_oh[bpos];
            it.tag = cur_tag[bpos];
        end else begin
            it.exp = tx_in;
            it.tag = "R8";
        end
        sbq.push_back(it);
        bpos++;
        if (bpos == FRAME_LEN) begin
            bpos = 0;
            for (int k = 0; k < OHB; k++) begin
                cur_oh[k]  = nxt_oh[k];
                cur_tag[k] = plan_tag[k];
            end
            frame++;
            make_plan(frame);
        end
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        check_bit("R1", "tx_out in reset", tx_out, 1'b0);
        check_bit("R1", "oh_clk in reset", oh_clk, 1'b0);
        check_bit("R1", "oh_frame in reset", oh_frame, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        rst_n  = 1'b0;
        tx_in  = 1'b0;
        oh_ins = 1'b0;
        oh_dat = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check_reset_state();
        end
        restart_model();
        rst_n = 1'b1;
        repeat (8 * FRAME_LEN) step();

        // reset in the middle of a frame
        repeat (17) step();
        rst_n = 1'b0;
        sbq.delete();
        @(negedge clk);
        check_reset_state();
        @(negedge clk);
        check_reset_state();
        restart_model();
        rst_n = 1'b1;
        repeat (3 * FRAME_LEN) step();
        @(negedge clk);
        finish_run();
    end

    // watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            mismatched++;
            $display("FAIL R2 watchdog: actual still running expected finished");
            finish_run();
        end
    end

endmodule